// File: doc/BRIEF.md
# TDM Serial Transmitter

This block is the transmit half of a time-division-multiplexed serial port. A repeating frame is split into equal word slots, one per channel. Each frame starts at a frame sync. The block either generates that sync itself (master) or takes it from a pin (slave). The sync's active level and the bit-clock edge used for all timing are programmable.

The first bit of channel 0 follows the frame sync after a programmable gap of 0 to 15 bit clocks. Because of that gap, the next frame sync can arrive while the tail of the current frame is still being shifted, so frames run back to back.

Words are delivered one at a time through a single-entry valid/ready buffer. Each enabled slot takes the next buffered word and shifts it MSB first. A data-valid output and a data-line enable are high for the whole of that word. Disabled slots leave the line undriven. An enabled slot that finds the buffer empty shifts zeros and sets a sticky underflow flag.

The block runs on a fast system clock `clk`. It detects edges of the bit clock `bclk`, which is assumed to be synchronous to `clk`. All frame state advances only on the selected bit-clock edge.

Top module: `tdm_tx`

## Requirements
- R1: In master mode `fs_oe` is 1 and `fs_out` is active for exactly one bit clock every `cfg_wlen*cfg_nch` bit clocks, starting on the first selected `bclk` edge after reset. In slave mode `fs_oe` is 0.
- R2: In slave mode a frame sync is recognised on the selected edge where `fs_in` first shows its active level after being inactive. A level held active for further edges does not restart the frame.
- R3: Bit 0 of slot 0 is presented `cfg_delay` selected edges after the edge that recognised the frame sync. With `cfg_delay`=0 it is presented on that same edge.
- R4: A frame sync whose start point falls while a frame is still being shifted restarts the sequence at slot 0, bit 0. In master mode with a nonzero delay, consecutive frames follow with no idle bit.
- R5: Slots are sent in order 0 to `cfg_nch`-1, each `cfg_wlen` bits long, MSB first. Bits of `tx_data` above `cfg_wlen`-1 are ignored. `tx_dv` and `sdo_oe` are 1 for every bit of a slot whose bit in `cfg_ch_en` is 1.
- R6: During a slot whose `cfg_ch_en` bit is 0, `tx_dv` and `sdo_oe` are 0. The buffered word is not used and goes out in the next enabled slot.
- R7: Between the last bit of a frame and the start of the next, `tx_dv` and `sdo_oe` are 0.
- R8: If the buffer is empty when an enabled slot begins, that slot drives zeros with `tx_dv`=1 and `underflow` becomes 1. `underflow` stays 1 until reset.
- R9: With `cfg_fs_act_low`=1 the active level of both `fs_out` and `fs_in` is 0.
- R10: With `cfg_fs_fall`=0 the block acts on rising `bclk` edges, otherwise on falling edges. Outputs do not change at the other edge.
- R11: `tx_ready` is 1 exactly when the buffer is empty, and a word is taken when `tx_valid` and `tx_ready` are both 1. In reset `tx_ready`=1, `tx_dv`=0, `sdo_oe`=0, `underflow`=0 and `fs_out` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, sampled by `clk` |
| cfg_master | input | 1 | 1 = generate frame sync, 0 = take it from `fs_in` |
| cfg_fs_act_low | input | 1 | Frame sync active level is low |
| cfg_fs_fall | input | 1 | Act on falling `bclk` edges |
| cfg_wlen | input | $clog2(MAX_WLEN+1) | Word length in bits, 3..MAX_WLEN |
| cfg_nch | input | $clog2(MAX_CH+1) | Slots per frame, 1..MAX_CH |
| cfg_delay | input | 4 | Bit clocks from frame sync to first bit |
| cfg_ch_en | input | MAX_CH | Per-slot enable mask, bit n = slot n |
| tx_data | input | MAX_WLEN | Word to send, right-justified |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Buffer empty, word will be taken |
| fs_in | input | 1 | Frame sync pin in slave mode |
| fs_out | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Frame sync pin drive enable |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Serial data drive enable |
| tx_dv | output | 1 | Enabled word being transmitted |
| underflow | output | 1 | Sticky: an enabled slot found the buffer empty |

## Verification
The bench builds the block with four channels and 8-bit maximum words, so whole frames are only a few dozen bits long. That size lets it sweep every combination of word lengths 3, 5 and 8, one, three and four slots, and delays from 0 up to just under the frame period. Enable masks, sync polarity and active edge are rotated across the runs. Slave runs add a two-bit-wide sync and an early sync that cuts a frame short. A run with no words fed covers the zero-fill and sticky-flag path.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    // width of the frame-sync-to-first-bit gap field
    localparam int DLY_W = 4;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } bclk_edge_e;

    typedef struct packed {
        logic       master;
        logic       act_low;
        bclk_edge_e edge_sel;
    } fs_mode_t;

    // what the data lane does during the current bit
    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_DATA = 2'd1,
        LANE_ZERO = 2'd2
    } lane_e;

    // convert an internal "sync active" flag to / from the pin level
    function automatic logic fs_pin_level(input logic active, input logic act_low);
        return active ^ act_low;
    endfunction

endpackage

// File: rtl/tdm_bclk_edge.sv
module tdm_bclk_edge
    import tdm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk,
    input  bclk_edge_e edge_sel,
    output logic       tick
);
    logic bclk_q;

    // the history register follows the pin in reset too, so no false edge
    always_ff @(posedge clk) begin
        if (rst) bclk_q <= bclk;
        else     bclk_q <= bclk;
    end

    logic rise, fall;
    assign rise = bclk & ~bclk_q;
    assign fall = ~bclk & bclk_q;
    assign tick = (edge_sel == EDGE_FALL) ? fall : rise;

endmodule

// File: rtl/tdm_fsync.sv
module tdm_fsync
    import tdm_tx_pkg::*;
#(
    parameter int PER_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  fs_mode_t         mode,
    input  logic [PER_W-1:0] period,
    input  logic             fs_in,
    output logic             fs_hit,
    output logic             fs_out,
    output logic             fs_oe
);
    logic [PER_W-1:0] cnt_q;
    logic             act_q;
    logic             prev_q;
    logic             pin_lvl;
    logic             gen_hit;
    logic             pin_hit;

    assign pin_lvl = fs_pin_level(fs_in, mode.act_low);
    assign gen_hit = tick && (cnt_q == '0);
    assign pin_hit = tick && pin_lvl && !prev_q;
    assign fs_hit  = mode.master ? gen_hit : pin_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            act_q  <= 1'b0;
            prev_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == period - PER_W'(1)) cnt_q <= '0;
            else                             cnt_q <= cnt_q + PER_W'(1);
            act_q  <= mode.master && (cnt_q == '0);
            prev_q <= pin_lvl;
        end
    end

    assign fs_out = fs_pin_level(act_q, mode.act_low);
    assign fs_oe  = mode.master;

    // R1
    gen_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        mode.master |-> (cnt_q < period));

    // R1
    gen_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.master && fs_hit) |=> act_q);

    // R2
    pin_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode.master && tick && prev_q) |-> !fs_hit);

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_tx_pkg::*;
#(
    parameter int WL_W   = 6,
    parameter int NCH_W  = 6,
    parameter int BIT_W  = 5,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fs_hit,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [WL_W-1:0]   cfg_wlen,
    input  logic [NCH_W-1:0]  cfg_nch,
    output logic              step_live,
    output logic              word_start,
    output logic [SLOT_W-1:0] step_slot
);
    logic              pend_q;
    logic [DLY_W-1:0]  dcnt_q;
    logic              live_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;

    logic              go;
    logic              n_live;
    logic [SLOT_W-1:0] n_slot;
    logic [BIT_W-1:0]  n_bit;
    logic              last_bit;
    logic              last_slot;

    assign go = tick && ((fs_hit && cfg_delay == '0) ||
                         (pend_q && dcnt_q == DLY_W'(1)));

    assign last_bit  = (WL_W'(bit_q) == cfg_wlen - WL_W'(1));
    assign last_slot = (NCH_W'(slot_q) == cfg_nch - NCH_W'(1));

    always_comb begin
        n_live = live_q;
        n_slot = slot_q;
        n_bit  = bit_q;
        if (go) begin
            n_live = 1'b1;
            n_slot = '0;
            n_bit  = '0;
        end else if (tick && live_q) begin
            if (last_bit) begin
                n_bit = '0;
                if (last_slot) begin
                    n_live = 1'b0;
                    n_slot = '0;
                end else begin
                    n_slot = slot_q + SLOT_W'(1);
                end
            end else begin
                n_bit = bit_q + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            dcnt_q <= '0;
            live_q <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
        end else begin
            live_q <= n_live;
            slot_q <= n_slot;
            bit_q  <= n_bit;
            if (tick) begin
                if (fs_hit && cfg_delay != '0) begin
                    pend_q <= 1'b1;
                    dcnt_q <= cfg_delay;
                end else if (pend_q) begin
                    if (dcnt_q == DLY_W'(1)) pend_q <= 1'b0;
                    dcnt_q <= dcnt_q - DLY_W'(1);
                end
            end
        end
    end

    assign step_live  = tick && n_live;
    assign word_start = (n_bit == '0);
    assign step_slot  = n_slot;

    // R3
    zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && fs_hit && cfg_delay == '0) |=> (live_q && slot_q == '0 && bit_q == '0));

    // R3
    dly_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (dcnt_q != '0));

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((WL_W'(bit_q) < cfg_wlen) && (NCH_W'(slot_q) < cfg_nch)));

endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter
    import tdm_tx_pkg::*;
#(
    parameter int MAX_CH   = 32,
    parameter int MAX_WLEN = 32,
    parameter int WL_W     = 6,
    parameter int SLOT_W   = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                step_live,
    input  logic                word_start,
    input  logic [SLOT_W-1:0]   step_slot,
    input  logic [MAX_CH-1:0]   cfg_ch_en,
    input  logic [WL_W-1:0]     cfg_wlen,
    input  logic [MAX_WLEN-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                tx_dv,
    output logic                underflow
);
    logic [MAX_WLEN-1:0] buf_q;
    logic                full_q;
    logic [MAX_WLEN-1:0] sh_q;
    lane_e               lane_q;
    logic                ufl_q;

    logic                accept;
    logic                slot_on;
    logic                begin_word;
    logic [WL_W-1:0]     gap;

    assign accept     = tx_valid && !full_q;
    assign slot_on    = cfg_ch_en[step_slot];
    assign begin_word = tick && step_live && word_start;
    assign gap        = WL_W'(MAX_WLEN) - cfg_wlen;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            sh_q   <= '0;
            lane_q <= LANE_IDLE;
            ufl_q  <= 1'b0;
        end else begin
            if (accept) begin
                buf_q  <= tx_data;
                full_q <= 1'b1;
            end
            if (tick) begin
                if (step_live && word_start) begin
                    if (slot_on) begin
                        if (full_q) begin
                            sh_q   <= buf_q << gap;
                            full_q <= 1'b0;
                            lane_q <= LANE_DATA;
                        end else begin
                            sh_q   <= '0;
                            lane_q <= LANE_ZERO;
                            ufl_q  <= 1'b1;
                        end
                    end else begin
                        lane_q <= LANE_IDLE;
                    end
                end else if (step_live) begin
                    sh_q <= sh_q << 1;
                end else begin
                    lane_q <= LANE_IDLE;
                end
            end
        end
    end

    assign tx_ready  = !full_q;
    assign sdo       = (lane_q == LANE_DATA) && sh_q[MAX_WLEN-1];
    assign sdo_oe    = (lane_q != LANE_IDLE);
    assign tx_dv     = (lane_q != LANE_IDLE);
    assign underflow = ufl_q;

    // R8
    ufl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R5
    drive_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(begin_word && slot_on));

    // R6
    consume_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(begin_word && slot_on));

    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_CH   = 32,
    parameter int MAX_WLEN = 32,
    localparam int WL_W    = $clog2(MAX_WLEN + 1),
    localparam int NCH_W   = $clog2(MAX_CH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                cfg_master,
    input  logic                cfg_fs_act_low,
    input  logic                cfg_fs_fall,
    input  logic [WL_W-1:0]     cfg_wlen,
    input  logic [NCH_W-1:0]    cfg_nch,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic [MAX_CH-1:0]   cfg_ch_en,
    input  logic [MAX_WLEN-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic                fs_in,
    output logic                fs_out,
    output logic                fs_oe,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                tx_dv,
    output logic                underflow
);
    localparam int BIT_W  = $clog2(MAX_WLEN);
    localparam int SLOT_W = $clog2(MAX_CH);
    localparam int PER_W  = $clog2(MAX_CH * MAX_WLEN + 1);

    fs_mode_t          mode;
    logic              tick;
    logic              fs_hit;
    logic [PER_W-1:0]  period;
    logic              step_live;
    logic              word_start;
    logic [SLOT_W-1:0] step_slot;

    assign mode.master   = cfg_master;
    assign mode.act_low  = cfg_fs_act_low;
    assign mode.edge_sel = bclk_edge_e'(cfg_fs_fall);
    assign period        = PER_W'(cfg_wlen) * PER_W'(cfg_nch);

    tdm_bclk_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .bclk     (bclk),
        .edge_sel (mode.edge_sel),
        .tick     (tick)
    );

    tdm_fsync #(.PER_W(PER_W)) u_fsync (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .mode   (mode),
        .period (period),
        .fs_in  (fs_in),
        .fs_hit (fs_hit),
        .fs_out (fs_out),
        .fs_oe  (fs_oe)
    );

    tdm_slot_seq #(
        .WL_W   (WL_W),
        .NCH_W  (NCH_W),
        .BIT_W  (BIT_W),
        .SLOT_W (SLOT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fs_hit     (fs_hit),
        .cfg_delay  (cfg_delay),
        .cfg_wlen   (cfg_wlen),
        .cfg_nch    (cfg_nch),
        .step_live  (step_live),
        .word_start (word_start),
        .step_slot  (step_slot)
    );

    tdm_word_shifter #(
        .MAX_CH   (MAX_CH),
        .MAX_WLEN (MAX_WLEN),
        .WL_W     (WL_W),
        .SLOT_W   (SLOT_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .step_live  (step_live),
        .word_start (word_start),
        .step_slot  (step_slot),
        .cfg_ch_en  (cfg_ch_en),
        .cfg_wlen   (cfg_wlen),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .tx_dv      (tx_dv),
        .underflow  (underflow)
    );

    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !step_live) |=> !tx_dv);

endmodule

// File: tb/tdm_tx_tb.sv
module tdm_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MCH  = 4;
    localparam int MWL  = 8;
    localparam int WL_W = $clog2(MWL + 1);
    localparam int NCH_W = $clog2(MCH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0;
    logic cfg_master = 1'b1, cfg_fs_act_low = 1'b0, cfg_fs_fall = 1'b0;
    logic [WL_W-1:0]  cfg_wlen = WL_W'(8);
    logic [NCH_W-1:0] cfg_nch = NCH_W'(4);
    logic [3:0]       cfg_delay = 4'd0;
    logic [MCH-1:0]   cfg_ch_en = '1;
    logic [MWL-1:0]   tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, fs_in = 1'b0, fs_out, fs_oe, sdo, sdo_oe, tx_dv, underflow;

    int n_chk = 0;
    int n_fail = 0;
    bit feed_on = 1'b0;
    int fidx = 0;
    bit done = 1'b0;

    tdm_tx #(.MAX_CH(MCH), .MAX_WLEN(MWL)) u_dut (
        .clk(clk), .rst(rst), .bclk(bclk),
        .cfg_master(cfg_master), .cfg_fs_act_low(cfg_fs_act_low), .cfg_fs_fall(cfg_fs_fall),
        .cfg_wlen(cfg_wlen), .cfg_nch(cfg_nch), .cfg_delay(cfg_delay), .cfg_ch_en(cfg_ch_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .fs_in(fs_in), .fs_out(fs_out), .fs_oe(fs_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_dv(tx_dv), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [MWL-1:0] word_fn(input int n);
        return MWL'((n * 29 + 11) ^ (n << 5));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11: feeder, a word is taken at the posedge following a negedge where ready was seen
    bit acc = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!feed_on) begin
                tx_valid = 1'b0;
                fidx = 0;
                acc = 1'b0;
            end else begin
                if (acc) fidx++;
                tx_valid = 1'b1;
                tx_data = word_fn(fidx);
                acc = tx_ready;
            end
        end
    end

    function automatic bit slave_fs(input int scn, input int k, input int p);
        if (scn == 0) return (k >= 2) && ((k - 2) % p == 0) && (k - 2 < 3 * p);
        return (k == 2) || (k == 3) || (k == p) || (k == 2 * p);
    endfunction

    task automatic run(input bit master, input bit act_low, input bit fall, input int wlen,
                       input int nch, input int dly, input logic [MCH-1:0] mask,
                       input int scn, input bit feeding, input string ctx);
        int p = wlen * nch;
        int nt = 3 * p + dly + 3;
        int pos = 0, pk = 0, widx = 0;
        bit live = 0, pv = 0, prev = 0, uf = 0;
        logic [MWL-1:0] cur_w = '0;
        @(negedge clk);
        feed_on = 1'b0;
        rst = 1'b1;
        cfg_master = master; cfg_fs_act_low = act_low; cfg_fs_fall = fall;
        cfg_wlen = WL_W'(wlen); cfg_nch = NCH_W'(nch); cfg_delay = 4'(dly); cfg_ch_en = mask;
        bclk = fall ? 1'b1 : 1'b0;
        fs_in = act_low;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(tx_ready == 1'b1, "R11 reset ready", tx_ready, 1);
        chk(tx_dv == 1'b0 && sdo_oe == 1'b0, "R11 reset dv/oe", {tx_dv, sdo_oe}, 0);
        chk(underflow == 1'b0, "R11 reset underflow", underflow, 0);
        chk(fs_out == act_low, "R11 R9 reset fs_out inactive", fs_out, act_low);
        chk(fs_oe == master, "R1 fs_oe", fs_oe, master);
        rst = 1'b0;
        feed_on = feeding;
        repeat (4) @(negedge clk);
        for (int k = 0; k < nt; k++) begin
            bit drv, fs_ev, start, drive, sbit, en;
            int sl, b;
            logic [3:0] snap;
            drv = master ? 1'b0 : slave_fs(scn, k, p);
            fs_in = act_low ^ drv;
            bclk = fall ? 1'b0 : 1'b1;
            @(negedge clk);
            fs_ev = master ? (k % p == 0) : (drv && !prev);
            if (!master) prev = drv;
            start = 1'b0;
            if (fs_ev && dly == 0) start = 1'b1;
            else if (pv && k == pk) begin start = 1'b1; pv = 1'b0; end
            if (fs_ev && dly != 0) begin pv = 1'b1; pk = k + dly; end
            if (start) begin live = 1'b1; pos = 0; end
            else if (live) begin pos++; if (pos == p) live = 1'b0; end
            drive = 1'b0; sbit = 1'b0;
            if (live) begin
                sl = pos / wlen; b = pos % wlen; en = mask[sl];
                if (b == 0 && en) begin
                    if (feeding) begin cur_w = word_fn(widx); widx++; end
                    else begin cur_w = '0; uf = 1'b1; end
                end
                drive = en;
                sbit = cur_w[wlen - 1 - b];
                chk(sdo_oe == drive, en ? $sformatf("R5 oe %s k=%0d", ctx, k)
                                        : $sformatf("R6 oe %s k=%0d", ctx, k), sdo_oe, drive);
                chk(tx_dv == drive, en ? $sformatf("R5 dv %s k=%0d", ctx, k)
                                       : $sformatf("R6 dv %s k=%0d", ctx, k), tx_dv, drive);
                if (drive)
                    chk(sdo == sbit, $sformatf("R5 R8 sdo %s k=%0d slot=%0d bit=%0d", ctx, k, sl, b),
                        sdo, sbit);
            end else begin
                chk(sdo_oe == 1'b0 && tx_dv == 1'b0, $sformatf("R7 idle %s k=%0d", ctx, k),
                    {sdo_oe, tx_dv}, 0);
            end
            if (master)
                chk(fs_out == (act_low ^ (k % p == 0)), $sformatf("R1 R9 fs_out %s k=%0d", ctx, k),
                    fs_out, act_low ^ (k % p == 0));
            chk(underflow == uf, $sformatf("R8 underflow %s k=%0d", ctx, k), underflow, uf);
            snap = {fs_out, sdo, sdo_oe, tx_dv};
            bclk = fall ? 1'b1 : 1'b0;
            @(negedge clk);
            chk({fs_out, sdo, sdo_oe, tx_dv} == snap, $sformatf("R10 other edge %s k=%0d", ctx, k),
                {fs_out, sdo, sdo_oe, tx_dv}, snap);
        end
    endtask

    initial begin
        int idx = 0;
        logic [MCH-1:0] masks [4] = '{4'b1111, 4'b0101, 4'b1010, 4'b0110};
        int wls [3] = '{3, 5, 8};
        int ncs [3] = '{1, 3, 4};
        int dls [5] = '{0, 1, 2, 7, 15};
        // master sweep: R1 R3 R4 R5 R6 R9 R10
        foreach (wls[wi]) foreach (ncs[ni]) foreach (dls[di]) begin
            if (dls[di] < wls[wi] * ncs[ni]) begin
                run(1'b1, idx[0], idx[1], wls[wi], ncs[ni], dls[di], masks[idx % 4], 0, 1'b1,
                    $sformatf("R3 R4 master w=%0d n=%0d d=%0d", wls[wi], ncs[ni], dls[di]));
                idx++;
            end
        end
        // slave runs: R2 R4
        run(1'b0, 1'b0, 1'b0, 5, 3, 0, 4'b1111, 0, 1'b1, "R2 slave");
        run(1'b0, 1'b1, 1'b1, 4, 4, 3, 4'b1011, 0, 1'b1, "R2 R9 slave delay");
        run(1'b0, 1'b0, 1'b1, 8, 2, 0, 4'b0011, 1, 1'b1, "R2 R4 slave wide+early");
        run(1'b0, 1'b1, 1'b0, 3, 4, 2, 4'b1101, 1, 1'b1, "R2 R4 slave early delay");
        // starvation: R8
        run(1'b1, 1'b0, 1'b0, 4, 2, 1, 4'b0011, 0, 1'b0, "R8 empty buffer");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule